// File: doc/BRIEF.md
# 5B Code-Group Aligner and Decoder

This block sits behind the descrambler of a 100 Mb/s twisted-pair receiver. It takes the recovered line as a stream of single bits, one bit per accepted transfer. It watches the idle line for the start of a frame and fixes the 5-bit code-group boundary at the start delimiter pair. From then on it turns each 5-bit code-group into a 4-bit nibble, with the usual media-independent receive qualifiers: data valid, receive error and carrier sense.

A valid frame opens with the 10-bit pair 11000 10001 after idle line. The pair is delivered as two preamble nibbles 0101. Data code-groups follow as nibbles. The frame closes on the end pair 01101 00111, or it is cut short by idle. When the line leaves idle without the start pair, the event counts as a false carrier. The block then reports error nibbles until the line has been idle for two code-groups, and it adds one to a saturating counter.

The bit input is a valid/ready stream. The ready output is held high at all times, so the block never applies back-pressure. A bit is consumed on every clock in which valid is high. Valid may stay low for any number of cycles. The nibble output is a valid-only stream and has no ready input, because a receive nibble interface cannot be stalled. A nibble is present for exactly the one cycle in which its valid is high.

Top module: `rx5b_align_decode`

## Requirements
- R1: `in_ready` is always 1. A bit is taken only in a cycle with `in_valid` high. The value on `in_bit` in other cycles has no effect on any output.
- R2: While hunting, a 0 bit that follows at least 7 consecutive 1 bits raises `crs` one cycle later. The 10 bits that start two bits before that 0 form the candidate, sent most significant bit first. If the candidate is 1100010001, the block locks to that 5-bit boundary. It then gives two nibbles 0101 with `rx_dv`=1 and `rx_er`=0, on consecutive cycles. A 0 after fewer than 7 ones leaves `crs` low.
- R3: In a frame, data code-groups decode to nibbles as follows: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F. Each such nibble has `rx_er`=0 and `rx_dv`=1.
- R4: The code-group 01101 followed directly by 00111 ends the frame. Neither code-group produces a nibble, and `rx_dv` and `crs` fall one cycle after the last bit.
- R5: In a frame, a first 11111 gives a nibble 0000 with `rx_er`=1. A second consecutive 11111 ends the frame and gives no nibble.
- R6: If the candidate is not the start pair, the block locks to its boundary. It gives one nibble 1110 with `rx_er`=1, `rx_dv`=0 and `crs`=1 for each code-group, starting from both candidate code-groups. This continues until the second consecutive 11111, which ends carrier and gives no nibble.
- R7: `fc_count` rises by exactly one for each bad start and changes at no other time.
- R8: In a frame, any code-group that is neither a data code nor handled by R4 or R5 gives a nibble 0000 with `rx_er`=1. When 01101 is not followed by 00111, the block gives a 0000 error nibble for it and then decodes the following code-group normally.
- R9: `fc_count` holds at all ones once it gets there. A high `fc_clr` sets it to zero at the next edge.
- R10: `rx_dv` is high only inside a valid frame. `crs` is high from the triggering 0 until the frame or bad start ends, and is low otherwise. A nibble never comes out while `crs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bit present on `in_bit` |
| in_ready | output | 1 | Always high; the block never stalls |
| in_bit | input | 1 | Descrambled line bit |
| out_valid | output | 1 | One-cycle strobe marking a nibble |
| rxd | output | 4 | Received nibble |
| rx_er | output | 1 | Error qualifier of the nibble |
| rx_dv | output | 1 | Inside a valid frame |
| crs | output | 1 | Carrier present |
| fc_clr | input | 1 | Synchronous clear of the false-carrier count |
| fc_count | output | CNT_W | Saturating false-carrier count |

## Verification
The assertions assume the preamble pair leaves the output on two cycles in a row. This holds only because a code-group takes five accepted bits. They also assume every bad start opens with a code-group that holds a 0. The stimulus keeps to this by opening bad starts with 11010 or 11011, and by placing at least one full idle code-group before every start. Bit offsets 0 to 4 are added before each frame. Random stall cycles with a random `in_bit` are placed between accepted bits, so the lock point and the ignore rule are both exercised under gaps.

// File: rtl/rx5b_pkg.sv
package rx5b_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * GRP_W;

  typedef enum logic [1:0] {ST_HUNT = 2'd0, ST_CAND = 2'd1, ST_PKT = 2'd2, ST_BAD = 2'd3} rx_state_e;

  typedef struct packed {
    logic             v;
    logic             er;
    logic [NIB_W-1:0] d;
  } nib_t;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] d;
  } dec_t;

  typedef struct packed {
    nib_t o;
    logic fin;
    logic idle;
    logic t;
  } pstep_t;

  typedef struct packed {
    nib_t o;
    logic fin;
    logic idle;
  } bstep_t;

  localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
  localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
  localparam logic [WIN_W-1:0] CG_JK   = 10'b1100010001;
  localparam logic [NIB_W-1:0] NB_PRE  = 4'b0101;
  localparam logic [NIB_W-1:0] NB_BAD  = 4'b1110;
  localparam logic [NIB_W-1:0] NB_ERR  = 4'b0000;

  function automatic dec_t cg_decode(input logic [GRP_W-1:0] g);
    dec_t r;
    r.ok = 1'b1;
    case (g)
      5'b11110: r.d = 4'h0;
      5'b01001: r.d = 4'h1;
      5'b10100: r.d = 4'h2;
      5'b10101: r.d = 4'h3;
      5'b01010: r.d = 4'h4;
      5'b01011: r.d = 4'h5;
      5'b01110: r.d = 4'h6;
      5'b01111: r.d = 4'h7;
      5'b10010: r.d = 4'h8;
      5'b10011: r.d = 4'h9;
      5'b10110: r.d = 4'hA;
      5'b10111: r.d = 4'hB;
      5'b11010: r.d = 4'hC;
      5'b11011: r.d = 4'hD;
      5'b11100: r.d = 4'hE;
      5'b11101: r.d = 4'hF;
      default: begin
        r.ok = 1'b0;
        r.d  = NB_ERR;
      end
    endcase
    return r;
  endfunction

  // One code-group inside a valid frame.
  function automatic pstep_t pkt_step(input logic [GRP_W-1:0] g, input logic idle_run);
    pstep_t r;
    dec_t   dd;
    r  = '0;
    dd = cg_decode(g);
    if (g == CG_IDLE) begin
      if (idle_run) begin
        r.fin = 1'b1;
      end else begin
        r.o    = '{v: 1'b1, er: 1'b1, d: NB_ERR};
        r.idle = 1'b1;
      end
    end else if (g == CG_T) begin
      r.t = 1'b1;
    end else begin
      r.o = '{v: 1'b1, er: !dd.ok, d: (dd.ok ? dd.d : NB_ERR)};
    end
    return r;
  endfunction

  // One code-group after a bad start.
  function automatic bstep_t bad_step(input logic [GRP_W-1:0] g, input logic idle_run);
    bstep_t r;
    r = '0;
    if (g == CG_IDLE && idle_run) begin
      r.fin = 1'b1;
    end else begin
      r.o    = '{v: 1'b1, er: 1'b1, d: NB_BAD};
      r.idle = (g == CG_IDLE);
    end
    return r;
  endfunction
endpackage

// File: rtl/rx5b_bitwin.sv
module rx5b_bitwin #(
  parameter int WIN_W    = 10,
  parameter int ONES_MAX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_nxt,
  output logic             armed
);
  localparam int OW = $clog2(ONES_MAX + 1);

  logic [WIN_W-2:0] win_q;
  logic [OW-1:0]    ones_q;

  assign win_nxt = {win_q, bit_in};
  assign armed   = (ones_q == OW'(ONES_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      ones_q <= '0;
    end else if (take) begin
      win_q <= win_nxt[WIN_W-2:0];
      if (!bit_in)     ones_q <= '0;
      else if (!armed) ones_q <= ones_q + 1'b1;
    end
  end

  // a taken zero always breaks the idle run
  p_ones_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bit_in) |=> !armed);
endmodule

// File: rtl/rx5b_grpcnt.sv
module rx5b_grpcnt #(
  parameter int GRP_W = 5,
  parameter int LEAD  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic load,
  output logic hit
);
  localparam int MAXV = (LEAD > GRP_W) ? LEAD : GRP_W;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q;

  assign hit = take && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= CW'(GRP_W);
    else if (load)  cnt_q <= CW'(LEAD);
    else if (hit)   cnt_q <= CW'(GRP_W);
    else if (take)  cnt_q <= cnt_q - 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CW'(MAXV)));
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load) |=> (cnt_q == CW'(GRP_W)));
endmodule

// File: rtl/rx5b_satcnt.sv
module rx5b_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && (cnt != '1))  cnt <= cnt + 1'b1;
  end

  p_fc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
  p_fc_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '1) && !clr) |=> (cnt == '1));
  p_fc_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/rx5b_align_decode.sv
module rx5b_align_decode
  import rx5b_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_er,
  output logic             rx_dv,
  output logic             crs,
  input  logic             fc_clr,
  output logic [CNT_W-1:0] fc_count
);
  localparam int LEAD_ONES = GRP_W + 2;
  localparam int CAND_LEFT = WIN_W - 3;

  logic             take;
  logic [WIN_W-1:0] win_nxt;
  logic             armed;
  logic             hit;
  logic             load_cand;
  logic             fc_inc;
  logic [GRP_W-1:0] grp;

  rx_state_e st_q, st_n;
  logic      idle_run_q, idle_run_n;
  logic      saw_t_q, saw_t_n;
  nib_t      pend_q, pend_n, emit, out_q;
  pstep_t    rp;
  bstep_t    rb;

  assign in_ready = 1'b1;
  assign take     = in_valid;
  assign grp      = win_nxt[GRP_W-1:0];

  rx5b_bitwin #(.WIN_W(WIN_W), .ONES_MAX(LEAD_ONES)) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(in_bit),
    .win_nxt(win_nxt), .armed(armed)
  );

  rx5b_grpcnt #(.GRP_W(GRP_W), .LEAD(CAND_LEFT)) u_grp (
    .clk(clk), .rst_n(rst_n), .take(take), .load(load_cand), .hit(hit)
  );

  rx5b_satcnt #(.W(CNT_W)) u_fc (
    .clk(clk), .rst_n(rst_n), .clr(fc_clr), .inc(fc_inc), .cnt(fc_count)
  );

  // A pending end code-group clears the idle run, so a group after it can never end the frame.
  assign rp = pkt_step(grp, saw_t_q ? 1'b0 : idle_run_q);
  // The first candidate group always holds a zero, so the second one cannot end the bad start.
  assign rb = bad_step(grp, (st_q == ST_CAND) ? 1'b0 : idle_run_q);

  always_comb begin
    st_n       = st_q;
    idle_run_n = idle_run_q;
    saw_t_n    = saw_t_q;
    emit       = '0;
    pend_n     = '0;
    load_cand  = 1'b0;
    fc_inc     = 1'b0;
    case (st_q)
      ST_HUNT: begin
        if (take && !in_bit && armed) begin
          st_n      = ST_CAND;
          load_cand = 1'b1;
        end
      end
      ST_CAND: begin
        if (hit) begin
          idle_run_n = 1'b0;
          saw_t_n    = 1'b0;
          if (win_nxt == CG_JK) begin
            st_n   = ST_PKT;
            emit   = '{v: 1'b1, er: 1'b0, d: NB_PRE};
            pend_n = '{v: 1'b1, er: 1'b0, d: NB_PRE};
          end else begin
            st_n       = ST_BAD;
            fc_inc     = 1'b1;
            emit       = '{v: 1'b1, er: 1'b1, d: NB_BAD};
            pend_n     = rb.o;
            idle_run_n = rb.idle;
          end
        end
      end
      ST_PKT: begin
        if (hit) begin
          if (saw_t_q && grp == CG_R) begin
            st_n       = ST_HUNT;
            saw_t_n    = 1'b0;
            idle_run_n = 1'b0;
          end else if (saw_t_q) begin
            emit       = '{v: 1'b1, er: 1'b1, d: NB_ERR};
            pend_n     = rp.o;
            idle_run_n = rp.idle;
            saw_t_n    = rp.t;
          end else if (rp.fin) begin
            st_n       = ST_HUNT;
            idle_run_n = 1'b0;
          end else begin
            emit       = rp.o;
            idle_run_n = rp.idle;
            saw_t_n    = rp.t;
          end
        end
      end
      default: begin
        if (hit) begin
          if (rb.fin) begin
            st_n       = ST_HUNT;
            idle_run_n = 1'b0;
          end else begin
            emit       = rb.o;
            idle_run_n = rb.idle;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_HUNT;
      idle_run_q <= 1'b0;
      saw_t_q    <= 1'b0;
      pend_q     <= '0;
      out_q      <= '0;
    end else begin
      st_q       <= st_n;
      idle_run_q <= idle_run_n;
      saw_t_q    <= saw_t_n;
      pend_q     <= pend_n;
      if (emit.v)        out_q <= emit;
      else if (pend_q.v) out_q <= pend_q;
      else               out_q.v <= 1'b0;
    end
  end

  assign out_valid = out_q.v;
  assign rxd       = out_q.d;
  assign rx_er     = out_q.er & out_q.v;
  assign rx_dv     = (st_q == ST_PKT);
  assign crs       = (st_q != ST_HUNT);

  p_dv_crs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);
  p_nib_carrier_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> crs);
  p_crs_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs) |-> !out_valid);
  p_pre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (out_valid && !rx_er && rxd == NB_PRE));
  p_pre_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |=> (out_valid && !rx_er && rxd == NB_PRE));
  p_bad_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rx_dv) |-> (rx_er && rxd == NB_BAD));
  p_fc_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fc_count != $past(fc_count)) && !$past(fc_clr)) |-> (out_valid && rx_er && !rx_dv));
endmodule

// File: tb/tb_rx5b_align_decode.sv
module tb_rx5b_align_decode;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int SAT_W      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic fc_clr = 1'b0;
  logic in_ready, out_valid, rx_er, rx_dv, crs;
  logic [3:0] rxd;
  logic [15:0] fc_count;
  logic s_ready, s_valid, s_er, s_dv, s_crs;
  logic [3:0] s_rxd;
  logic [SAT_W-1:0] s_fc;

  int n_chk = 0;
  int n_err = 0;
  int fc_exp = 0;
  int cyc = 0;
  logic [6:0] gotq[$];
  logic [6:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx5b_align_decode #(.CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .rxd(rxd), .rx_er(rx_er), .rx_dv(rx_dv), .crs(crs),
    .fc_clr(fc_clr), .fc_count(fc_count)
  );

  rx5b_align_decode #(.CNT_W(SAT_W)) dut_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(s_ready), .in_bit(in_bit),
    .out_valid(s_valid), .rxd(s_rxd), .rx_er(s_er), .rx_dv(s_dv), .crs(s_crs),
    .fc_clr(fc_clr), .fc_count(s_fc)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) gotq.push_back({crs, rx_dv, rx_er, rxd});
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  // R1: stall cycles carry a random in_bit that must be ignored
  task automatic send_bit(input logic b);
    if ($urandom_range(0, 3) == 0) begin
      in_valid = 1'b0;
      in_bit   = 1'($urandom_range(0, 1));
      repeat ($urandom_range(1, 3)) @(posedge clk);
      #1;
    end
    in_valid = 1'b1;
    in_bit   = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_idle(input int n);
    repeat (n) send_grp(5'b11111);
  endtask

  task automatic push_exp(input logic dv, input logic er, input logic [3:0] nib);
    expq.push_back({1'b1, dv, er, nib});
  endtask

  task automatic open_frame(input int off);
    repeat (off) send_bit(1'b1);
    send_idle(1);
  endtask

  task automatic finish_frame(input string req);
    int n;
    send_idle(2);
    repeat (4) @(posedge clk);
    #1;
    chk(gotq.size() == expq.size(), {req, " nibble count"}, gotq.size(), expq.size());
    n = (gotq.size() < expq.size()) ? gotq.size() : expq.size();
    for (int i = 0; i < n; i++)
      chk(gotq[i] == expq[i], {req, " nibble {crs,dv,er,rxd}"}, int'(gotq[i]), int'(expq[i]));
    chk(!crs && !rx_dv, "R10 carrier low after frame", int'({crs, rx_dv}), 0);
    chk(fc_count == 16'(fc_exp), "R7 false-carrier count", int'(fc_count), fc_exp);
    chk(s_fc == SAT_W'((fc_exp > 3) ? 3 : fc_exp), "R9 saturating count",
        int'(s_fc), (fc_exp > 3) ? 3 : fc_exp);
    gotq.delete();
    expq.delete();
  endtask

  task automatic frame_good(input int off, input int n, input bit idle_end, input bit rnd,
                            input int base, input bit stall, input string req);
    logic [3:0] d;
    open_frame(off);
    send_grp(5'b11000);
    send_grp(5'b10001);
    push_exp(1'b1, 1'b0, 4'b0101);
    push_exp(1'b1, 1'b0, 4'b0101);
    if (stall) begin
      for (int k = 0; k < 20; k++) begin
        in_valid = 1'b0;
        in_bit   = 1'(k & 1);
        @(posedge clk);
        #1;
      end
    end
    for (int i = 0; i < n; i++) begin
      d = rnd ? 4'($urandom_range(0, 15)) : 4'((base + i) % 16);
      send_grp(enc(d));
      push_exp(1'b1, 1'b0, d);
    end
    if (idle_end) begin
      send_grp(5'b11111);
      push_exp(1'b1, 1'b1, 4'b0000);
      send_grp(5'b11111);
    end else begin
      send_grp(5'b01101);
      send_grp(5'b00111);
    end
    finish_frame(req);
  endtask

  task automatic frame_bad(input int off, input int k);
    open_frame(off);
    send_grp(($urandom_range(0, 1) == 1) ? 5'b11010 : 5'b11011);
    for (int i = 1; i < k; i++) send_grp(enc(4'($urandom_range(0, 15))));
    for (int i = 0; i <= k; i++) push_exp(1'b0, 1'b1, 4'b1110);
    fc_exp++;
    finish_frame("R6 bad start");
  endtask

  task automatic frame_err(input int off);
    logic [3:0] d1, d2;
    d1 = 4'($urandom_range(0, 15));
    d2 = 4'($urandom_range(0, 15));
    open_frame(off);
    send_grp(5'b11000);
    send_grp(5'b10001);
    push_exp(1'b1, 1'b0, 4'b0101);
    push_exp(1'b1, 1'b0, 4'b0101);
    send_grp(enc(d1));
    push_exp(1'b1, 1'b0, d1);
    send_grp(5'b01101);
    send_grp(enc(d2));
    push_exp(1'b1, 1'b1, 4'b0000);
    push_exp(1'b1, 1'b0, d2);
    send_grp(5'b00000);
    push_exp(1'b1, 1'b1, 4'b0000);
    send_grp(5'b01101);
    send_grp(5'b00111);
    finish_frame("R8 invalid code and lone end group");
  endtask

  initial begin
    void'($urandom(32'd5489));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    chk(!out_valid && !crs && !rx_dv, "R10 reset outputs quiet", int'({out_valid, crs, rx_dv}), 0);
    chk(fc_count == 16'd0, "R7 reset count", int'(fc_count), 0);
    chk(in_ready == 1'b1, "R1 ready high", int'(in_ready), 1);

    // R2: a zero after too few ones does not raise carrier
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk(!crs && gotq.size() == 0, "R2 no trigger without idle", int'(crs), 0);
    send_idle(2);

    // R2/R3/R4: every offset, all sixteen data codes, end on the end pair
    for (int off = 0; off < 5; off++)
      frame_good(off, 16, 1'b0, 1'b0, off, 1'b0, "R3 decode, R4 end pair");
    frame_good(2, 3, 1'b1, 1'b1, 0, 1'b0, "R5 end on idle");
    frame_good(1, 3, 1'b1, 1'b0, 0, 1'b1, "R5 end on idle");
    frame_good(3, 4, 1'b0, 1'b1, 0, 1'b1, "R1 stall ignored");
    frame_err(0);
    frame_err(4);
    for (int k = 1; k <= 4; k++) frame_bad(k, k);

    // R9: clear
    fc_clr = 1'b1;
    @(posedge clk);
    #1;
    fc_clr = 1'b0;
    fc_exp = 0;
    chk(fc_count == 16'd0 && s_fc == '0, "R9 clear", int'(fc_count), 0);

    for (int f = 0; f < 40; f++) begin
      case ($urandom_range(0, 3))
        0: frame_good(int'($urandom_range(0, 4)), int'($urandom_range(1, 12)), 1'b0, 1'b1, 0, 1'b0, "R3 random, R4 end");
        1: frame_good(int'($urandom_range(0, 4)), int'($urandom_range(1, 12)), 1'b1, 1'b1, 0, 1'b0, "R3 random, R5 end");
        2: frame_bad(int'($urandom_range(0, 4)), int'($urandom_range(1, 5)));
        default: frame_err(int'($urandom_range(0, 4)));
      endcase
    end

    summary();
    $finish;
  end
endmodule